// File: doc/BRIEF.md
# Extended Control Register for a FIFO-Backed Parallel Port

This block is the extended control register of a parallel-port controller that moves data through a FIFO. Software reads and writes one 8-bit register. The register holds a 3-bit operating mode, an error-interrupt mask, a DMA enable and a service-request flag. It also shows FIFO full and FIFO empty as read-only bits. The block watches the fault line coming back from the peripheral, and it raises a one-clock interrupt pulse when a fault starts or when a service condition occurs.

The service flag is set by hardware and cleared by software. Which condition sets it depends on the DMA enable and on the transfer direction: a DMA terminal count, enough free room in the FIFO, or enough data waiting in the FIFO. The block also polices mode changes. The transfer direction can only be changed in the software-reverse mode. A hardware mode can only be left once the FIFO is drained, and only to a software mode. A mode write that breaks these rules is refused and recorded in a sticky status output.

Top module: `ecp_ctrl_reg`

## Requirements
- R1: The read value is {mode[7:5], fault-mask[4], DMA-enable[3], service-flag[2], full[1], empty[0]}. After reset it is mode 000, mask 1, DMA enable 0, service flag 1, so it reads 8'h15 while the FIFO is empty.
- R2: Bit 1 reads 1 exactly when the fill level equals DEPTH. Bit 0 reads 1 exactly when the fill level is 0. Written values of bits 1:0 are ignored.
- R3: `dma_run` is high exactly when the DMA enable is 1 and the service flag is 0.
- R4: When the DMA enable is 1 and the service flag is 0, a terminal-count pulse sets the flag at the next edge and gives one `irq_pulse`.
- R5: When the DMA enable is 0, the latched direction is forward (0) and the service flag is 0, the flag is set and an `irq_pulse` is given once DEPTH minus the fill level is at least WR_THR.
- R6: When the DMA enable is 0, the latched direction is reverse (1) and the service flag is 0, the flag is set and an `irq_pulse` is given once the fill level is at least RD_THR.
- R7: A register write loads bits 4:2 as written. A written 1 in bit 2 never gives an interrupt. A write takes precedence over a hardware set in the same cycle.
- R8: In mode 011 with bit 4 at 0, a falling edge on `fault_n` gives exactly one `irq_pulse`, at the third rising edge after the fall, because of a two-flop synchronizer and an edge detector. No pulse is given in other modes or when bit 4 is 1.
- R9: In mode 011, a write that takes bit 4 from 1 to 0 while the synchronized `fault_n` is low gives an `irq_pulse` at that write's edge.
- R10: From mode 000 or 001, a write of any mode is accepted.
- R11: From a mode of 010 or above, a write of a different mode of 010 or above is refused.
- R12: From a mode of 010 or above, a write of 000 or 001 is accepted only if the FIFO is empty and, when the direction is forward, `ctl_idle` is 1.
- R13: A refused mode write leaves the mode unchanged and sets `bad_mode`, which stays 1 until reset. Bits 4:2 of the same write still take effect.
- R14: `port_rev` loads `dir_req` at each edge only while the mode is 001. In every other mode it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| fault_n | input | 1 | Peripheral fault line, active low, asynchronous |
| fifo_level | input | LVL_W | FIFO fill level in bytes |
| dma_tc | input | 1 | DMA terminal-count pulse |
| dir_req | input | 1 | Requested direction (1 = reverse) |
| ctl_idle | input | 1 | All port control lines deasserted |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| dma_run | output | 1 | DMA requests allowed |
| mode_o | output | 3 | Current mode |
| port_rev | output | 1 | Latched direction (1 = reverse) |
| bad_mode | output | 1 | Sticky refused-mode-write status |

## Verification
If the service flag holds a wrong value, it shows up in the same cycle on `dma_run` and on bit 2 of the read value. If it is set at the wrong time, an `irq_pulse` appears or goes missing one edge after the condition. A wrong synchronizer or edge-detector state moves the fault pulse away from the third edge after `fault_n` falls, or doubles it. A wrong mode or direction register shows up at once on `mode_o` or `port_rev`, and it then changes which threshold sets the service flag. A reference model in the bench is compared against every output at every falling edge.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  typedef enum logic [2:0] {
    MODE_SW_FWD = 3'b000,
    MODE_SW_REV = 3'b001,
    MODE_HW_FWD = 3'b010,
    MODE_HW_ECP = 3'b011,
    MODE_HW_4   = 3'b100,
    MODE_HW_5   = 3'b101,
    MODE_HW_6   = 3'b110,
    MODE_HW_7   = 3'b111
  } ecp_mode_e;

  localparam int unsigned BIT_MASK = 4;
  localparam int unsigned BIT_DMA  = 3;
  localparam int unsigned BIT_SVC  = 2;

  function automatic logic is_sw_mode(input logic [2:0] m);
    return (m[2:1] == 2'b00);
  endfunction
endpackage

// File: rtl/ecp_rst_sync.sv
module ecp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ecp_fault_irq.sv
module ecp_fault_irq #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n,
  input  logic armed,
  input  logic unmask_wr,
  output logic fault_low,
  output logic fault_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], fault_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    fault_low = ~sync_q[SYNC_STAGES-1];
    fall      = prev_q & fault_low;
    fault_evt = (armed & fall) | (unmask_wr & fault_low);
  end
endmodule

// File: rtl/ecp_mode_ctl.sv
module ecp_mode_ctl
  import ecp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] req_mode,
  input  logic       dir_req,
  input  logic       fifo_empty,
  input  logic       ctl_idle,
  output logic [2:0] mode,
  output logic       dir_rev,
  output logic       bad
);
  logic [2:0] mode_q, mode_d;
  logic       dir_q, dir_d;
  logic       bad_q, bad_d;
  logic       change, legal, drained;

  always_comb begin
    change  = wr && (req_mode != mode_q);
    drained = fifo_empty && (dir_q || ctl_idle);
    if (is_sw_mode(mode_q))        legal = 1'b1;
    else if (is_sw_mode(req_mode)) legal = drained;
    else                           legal = 1'b0;

    mode_d = mode_q;
    bad_d  = bad_q;
    if (change) begin
      if (legal) mode_d = req_mode;
      else       bad_d  = 1'b1;
    end

    dir_d = (mode_q == MODE_SW_REV) ? dir_req : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SW_FWD;
      dir_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      bad_q  <= bad_d;
    end
  end

  assign mode    = mode_q;
  assign dir_rev = dir_q;
  assign bad     = bad_q;
endmodule

// File: rtl/ecp_svc_flag.sv
module ecp_svc_flag #(
  parameter int unsigned DEPTH  = 16,
  parameter logic [3:0]  WR_THR = 4'd8,
  parameter logic [3:0]  RD_THR = 4'd8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wr_dma_en,
  input  logic             wr_svc,
  input  logic [LVL_W-1:0] level,
  input  logic             dma_tc,
  input  logic             dir_rev,
  output logic             dma_en,
  output logic             svc,
  output logic             svc_set
);
  localparam int unsigned CMP_W = (LVL_W > 4) ? LVL_W : 4;

  logic             dma_q, dma_d;
  logic             svc_q, svc_d;
  logic             cond;
  logic [CMP_W-1:0] free_c, lvl_c, wthr_c, rthr_c;

  always_comb begin
    lvl_c  = CMP_W'(level);
    free_c = CMP_W'(DEPTH) - lvl_c;
    wthr_c = CMP_W'(WR_THR);
    rthr_c = CMP_W'(RD_THR);
    if (dma_q)        cond = dma_tc;
    else if (dir_rev) cond = (lvl_c >= rthr_c);
    else              cond = (free_c >= wthr_c);

    svc_set = !wr && !svc_q && cond;
    dma_d   = wr ? wr_dma_en : dma_q;
    svc_d   = wr ? wr_svc    : (svc_q | cond);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q <= 1'b0;
      svc_q <= 1'b1;
    end else begin
      dma_q <= dma_d;
      svc_q <= svc_d;
    end
  end

  assign dma_en = dma_q;
  assign svc    = svc_q;
endmodule

// File: rtl/ecp_ctrl_reg.sv
module ecp_ctrl_reg
  import ecp_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter logic [3:0]  WR_THR = 4'd8,
  parameter logic [3:0]  RD_THR = 4'd8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             fault_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             dma_tc,
  input  logic             dir_req,
  input  logic             ctl_idle,
  output logic             irq_pulse,
  output logic             dma_run,
  output logic [2:0]       mode_o,
  output logic             port_rev,
  output logic             bad_mode
);
  logic       rst_i_n;
  logic       mask_q, mask_d;
  logic       irq_q, irq_d;
  logic       fifo_full, fifo_empty;
  logic       dma_en, svc, svc_set;
  logic       fault_low, fault_evt;
  logic       in_ecp, armed, unmask_wr;
  logic [2:0] mode;
  logic       dir_rev, bad;

  ecp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  always_comb begin
    fifo_full  = (fifo_level == LVL_W'(DEPTH));
    fifo_empty = (fifo_level == '0);
    in_ecp     = (mode == MODE_HW_ECP);
    armed      = in_ecp && !mask_q;
    unmask_wr  = in_ecp && reg_wr && mask_q && !reg_wdata[BIT_MASK];
  end

  ecp_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .req_mode(reg_wdata[7:5]),
    .dir_req(dir_req), .fifo_empty(fifo_empty), .ctl_idle(ctl_idle),
    .mode(mode), .dir_rev(dir_rev), .bad(bad)
  );

  ecp_fault_irq #(.SYNC_STAGES(2)) u_fault (
    .clk(clk), .rst_n(rst_i_n), .fault_n(fault_n), .armed(armed),
    .unmask_wr(unmask_wr), .fault_low(fault_low), .fault_evt(fault_evt)
  );

  ecp_svc_flag #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) u_svc (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr),
    .wr_dma_en(reg_wdata[BIT_DMA]), .wr_svc(reg_wdata[BIT_SVC]),
    .level(fifo_level), .dma_tc(dma_tc), .dir_rev(dir_rev),
    .dma_en(dma_en), .svc(svc), .svc_set(svc_set)
  );

  always_comb begin
    mask_d = reg_wr ? reg_wdata[BIT_MASK] : mask_q;
    irq_d  = fault_evt | svc_set;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mask_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign reg_rdata = {mode, mask_q, dma_en, svc, fifo_full, fifo_empty};
  assign irq_pulse = irq_q;
  assign dma_run   = dma_en & ~svc;
  assign mode_o    = mode;
  assign port_rev  = dir_rev;
  assign bad_mode  = bad;
endmodule

// File: rtl/ecp_ctrl_reg_chk.sv
module ecp_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       dma_run,
  input logic [2:0] mode_o,
  input logic       port_rev,
  input logic       bad_mode
);
  // R2
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rdata[1] && reg_rdata[0]));

  // R3
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_run |-> (reg_rdata[3] && !reg_rdata[2]));

  // R7
  svc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] && !reg_wr) |=> reg_rdata[2]);

  // R11
  hw_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && mode_o[2:1] != 2'b00 && reg_wdata[7:6] != 2'b00 &&
     reg_wdata[7:5] != mode_o) |=> ($stable(mode_o) && bad_mode));

  // R13
  bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |=> bad_mode);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(mode_o));

  // R14
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 3'b001) |=> $stable(port_rev));
endmodule

bind ecp_ctrl_reg ecp_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .dma_run(dma_run), .mode_o(mode_o),
  .port_rev(port_rev), .bad_mode(bad_mode)
);

// File: tb/test_ecp_ctrl_reg.sv
module test_ecp_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int WR_THR = 8;
  localparam int RD_THR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic fault_n = 1'b1;
  logic [LVL_W-1:0] fifo_level = '0;
  logic dma_tc = 1'b0, dir_req = 1'b0, ctl_idle = 1'b1;
  logic irq_pulse, dma_run, port_rev, bad_mode;
  logic [2:0] mode_o;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 1'b0;

  ecp_ctrl_reg #(.DEPTH(DEPTH), .WR_THR(4'(WR_THR)), .RD_THR(4'(RD_THR))) i_ecp_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fault_n(fault_n), .fifo_level(fifo_level),
    .dma_tc(dma_tc), .dir_req(dir_req), .ctl_idle(ctl_idle),
    .irq_pulse(irq_pulse), .dma_run(dma_run), .mode_o(mode_o),
    .port_rev(port_rev), .bad_mode(bad_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic ms1, ms2, f1, f2, f3;
  logic [2:0] m_mode;
  logic m_mask, m_dma, m_svc, m_dir, m_bad, m_irq;

  function automatic logic svc_cond(logic dma, logic dir, int lvl, logic tc);
    if (dma) return tc;
    if (dir) return lvl >= RD_THR;
    return (DEPTH - lvl) >= WR_THR;
  endfunction

  function automatic logic mode_ok(logic [2:0] cur, logic [2:0] req, int lvl,
                                   logic dir, logic idle);
    if (cur < 3'd2) return 1'b1;
    if (req >= 3'd2) return 1'b0;
    return (lvl == 0) && (dir || idle);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 <= 0; ms2 <= 0; f1 <= 1; f2 <= 1; f3 <= 1;
      m_mode <= 0; m_mask <= 1; m_dma <= 0; m_svc <= 1; m_dir <= 0; m_bad <= 0; m_irq <= 0;
    end else begin
      ms1 <= 1'b1; ms2 <= ms1;
      if (ms2) begin
        logic c, fe;
        f1 <= fault_n; f2 <= f1; f3 <= f2;
        c  = svc_cond(m_dma, m_dir, int'(fifo_level), dma_tc);
        fe = (m_mode == 3 && !m_mask && f3 && !f2) ||
             (m_mode == 3 && reg_wr && m_mask && !reg_wdata[4] && !f2);
        m_irq <= fe || (!reg_wr && !m_svc && c);
        if (reg_wr) begin
          m_mask <= reg_wdata[4]; m_dma <= reg_wdata[3]; m_svc <= reg_wdata[2];
          if (reg_wdata[7:5] != m_mode) begin
            if (mode_ok(m_mode, reg_wdata[7:5], int'(fifo_level), m_dir, ctl_idle))
              m_mode <= reg_wdata[7:5];
            else m_bad <= 1'b1;
          end
        end else m_svc <= m_svc | c;
        if (m_mode == 3'd1) m_dir <= dir_req;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_rd;
    exp_rd = {m_mode, m_mask, m_dma, m_svc, fifo_level == DEPTH, fifo_level == 0};
    check(reg_rdata[7:5] == exp_rd[7:5], "R10 mode field", reg_rdata[7:5], exp_rd[7:5]);
    check(reg_rdata[4:2] == exp_rd[4:2], "R7 control bits", reg_rdata[4:2], exp_rd[4:2]);
    check(reg_rdata[1:0] == exp_rd[1:0], "R2 full/empty", reg_rdata[1:0], exp_rd[1:0]);
    check(irq_pulse == m_irq, "R8 irq_pulse", irq_pulse, m_irq);
    check(dma_run == (m_dma && !m_svc), "R3 dma_run", dma_run, m_dma && !m_svc);
    check(mode_o == m_mode, "R12 mode_o", mode_o, m_mode);
    check(port_rev == m_dir, "R14 port_rev", port_rev, m_dir);
    check(bad_mode == m_bad, "R13 bad_mode", bad_mode, m_bad);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    if (irq_pulse) irq_cnt++;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int c0;
    void'($urandom(32'h5eed_1284));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset value
    check(reg_rdata == 8'h15, "R1 reset readback", reg_rdata, 8'h15);

    // R10 software mode to ECP mode, mask cleared, flag kept set
    wr({3'b011, 1'b0, 1'b0, 1'b1, 2'b11});
    check(mode_o == 3'b011, "R10 enter 011", mode_o, 3);

    // R8 falling fault edge gives a single pulse, on the third edge
    c0 = irq_cnt; fault_n = 1'b0;
    tick(); tick();
    check(irq_pulse == 1'b0, "R8 no early pulse", irq_pulse, 0);
    tick();
    check(irq_pulse == 1'b1, "R8 pulse on third edge", irq_pulse, 1);
    repeat (4) tick();
    check(irq_cnt - c0 == 1, "R8 single pulse", irq_cnt - c0, 1);

    // R9 unmasking while the fault line is already low
    wr({3'b011, 1'b1, 1'b0, 1'b1, 2'b00});
    repeat (3) tick();
    c0 = irq_cnt;
    wr({3'b011, 1'b0, 1'b0, 1'b1, 2'b00});
    check(irq_pulse == 1'b1, "R9 unmask pulse", irq_pulse, 1);
    fault_n = 1'b1; repeat (4) tick();

    // R11 R13 direct hop between hardware modes is refused
    wr({3'b010, 1'b1, 1'b0, 1'b1, 2'b00});
    check(mode_o == 3'b011 && bad_mode, "R11 hop refused", {mode_o, bad_mode}, {3'd3, 1'b1});
    check(reg_rdata[4] == 1'b1, "R13 other bits applied", reg_rdata[4], 1);

    // R12 leaving needs an empty FIFO
    fifo_level = 5; tick();
    wr({3'b001, 1'b1, 1'b0, 1'b1, 2'b00});
    check(mode_o == 3'b011, "R12 refused while not empty", mode_o, 3);
    fifo_level = 0; ctl_idle = 1'b0; tick();
    wr({3'b001, 1'b1, 1'b0, 1'b1, 2'b00});
    check(mode_o == 3'b011, "R12 refused while lines active", mode_o, 3);
    ctl_idle = 1'b1; tick();
    wr({3'b001, 1'b1, 1'b0, 1'b1, 2'b00});
    check(mode_o == 3'b001, "R12 accepted when drained", mode_o, 1);

    // R14 direction follows only in 001
    dir_req = 1'b1; tick(); tick();
    check(port_rev == 1'b1, "R14 dir latched", port_rev, 1);
    wr({3'b000, 1'b1, 1'b0, 1'b1, 2'b00});
    dir_req = 1'b0; repeat (3) tick();
    check(port_rev == 1'b1, "R14 dir held", port_rev, 1);

    // R6 reverse read threshold
    fifo_level = LVL_W'(RD_THR - 1); tick();
    wr({3'b000, 1'b1, 1'b0, 1'b0, 2'b00});
    tick();
    check(reg_rdata[2] == 1'b0, "R6 below threshold", reg_rdata[2], 0);
    fifo_level = LVL_W'(RD_THR); tick();
    check(irq_pulse && reg_rdata[2], "R6 threshold set", {irq_pulse, reg_rdata[2]}, 3);

    // R3 R4 DMA terminal count
    wr({3'b000, 1'b1, 1'b1, 1'b0, 2'b00});
    check(dma_run == 1'b1, "R3 dma runs", dma_run, 1);
    dma_tc = 1'b1; tick(); dma_tc = 1'b0;
    check(irq_pulse && !dma_run, "R4 terminal count", {irq_pulse, dma_run}, 2);

    // R7 writing 1 to the flag gives no interrupt
    c0 = irq_cnt;
    wr({3'b000, 1'b1, 1'b0, 1'b1, 2'b00}); tick();
    check(irq_cnt == c0, "R7 no pulse on write", irq_cnt - c0, 0);

    // R5 forward free-space threshold
    wr({3'b001, 1'b1, 1'b0, 1'b1, 2'b00});
    tick(); tick();
    wr({3'b000, 1'b1, 1'b0, 1'b1, 2'b00});
    fifo_level = LVL_W'(DEPTH - WR_THR + 1); tick();
    wr({3'b000, 1'b1, 1'b0, 1'b0, 2'b00}); tick();
    check(reg_rdata[2] == 1'b0, "R5 not enough room", reg_rdata[2], 0);
    fifo_level = LVL_W'(DEPTH - WR_THR); tick();
    check(irq_pulse == 1'b1, "R5 room reached", irq_pulse, 1);

    // R2 full reading, written low bits ignored
    fifo_level = LVL_W'(DEPTH);
    wr({3'b000, 1'b1, 1'b0, 1'b1, 2'b01});
    check(reg_rdata[1:0] == 2'b10, "R2 full bit", reg_rdata[1:0], 2);

    // constrained random phase, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_wdata = {3'($urandom_range(0, (i % 3 == 0) ? 7 : 3)), 5'($urandom)};
      if ($urandom_range(0, 7) == 0) fault_n = ~fault_n;
      if ($urandom_range(0, 3) == 0) fifo_level = LVL_W'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 5) == 0) fifo_level = '0;
      dma_tc = ($urandom_range(0, 15) == 0);
      dir_req = $urandom_range(0, 1);
      ctl_idle = ($urandom_range(0, 3) != 0);
      tick();
    end
    reg_wr = 1'b0;
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule